// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of an 8-bit successive-approximation converter. On a start strobe it captures a channel number for the eight-way analog multiplexer and two 4-bit codes that set the internal upper and lower reference levels. It then runs a fixed sequence. First comes a load window, in which the sampling capacitor charges. A hold window follows, in which the input must stay still. Last comes a binary search that takes one decision per cycle. In each search cycle the block drives a trial code to an external DAC and reads back one comparator bit.

When the last bit has been decided, the block writes the code to the result register and raises an interrupt request. It then goes idle, or in continuous mode it starts the next conversion at once. The comparator, the DAC and the reference ladder are outside the block. The testbench models them.

Top module: `sar_sequencer`

## Requirements
- R1: After reset these outputs are all zero: busy_o, load_o, sample_o, trial_o, result_o and irq_o.
- R2: A start_i high at a rising edge latches chan_i (a 3-bit channel index) onto chan_sel_o and sets busy_o from the next cycle. Changes on chan_i have no effect on chan_sel_o until the next conversion start.
- R3: For the first 2 cycles after a start, load_o is high. For the first 4 cycles, sample_o is high. trial_o is zero during the whole sample window.
- R4: The search then runs for 8 cycles, from the MSB down to the LSB. In the cycle that decides bit b, trial_o holds the bits already decided above b, a one at bit b, and zeros below b. cmp_i high in that cycle keeps bit b as one. cmp_i low clears it.
- R5: At the edge that ends the 12th cycle after a start, result_o takes the decided code and irq_o is set. busy_o drops at that edge unless a new conversion starts.
- R6: irq_o stays set until irq_clr_i is high at an edge. If a completion and irq_clr_i fall on the same edge, irq_o ends up set.
- R7: If cont_i is high at the completion edge, a new conversion starts on that edge. The new conversion samples chan_i and both reference codes again.
- R8: A start_i during a conversion abandons that conversion without writing result_o or irq_o. It restarts the full sequence on the newly given channel.
- R9: ref_hi_o and ref_lo_o take ref_hi_i and ref_lo_i (4-bit, 16 steps each) at every conversion start. They hold those values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Conversion start strobe |
| chan_i | input | 3 | Channel to convert |
| cont_i | input | 1 | 1 = continuous conversion, 0 = single |
| ref_hi_i | input | 4 | Upper internal reference step |
| ref_lo_i | input | 4 | Lower internal reference step |
| cmp_i | input | 1 | Comparator: input at or above trial level |
| irq_clr_i | input | 1 | Clears the end-of-conversion request |
| busy_o | output | 1 | Conversion in progress |
| load_o | output | 1 | Load window active |
| sample_o | output | 1 | Sample window (load plus hold) active |
| chan_sel_o | output | 3 | Multiplexer channel select |
| trial_o | output | 8 | Trial code to the DAC |
| ref_hi_o | output | 4 | Latched upper reference step |
| ref_lo_o | output | 4 | Latched lower reference step |
| result_o | output | 8 | Last completed conversion result |
| irq_o | output | 1 | End-of-conversion interrupt request |

## Verification
A start strobe seen at one edge changes busy_o, chan_sel_o, the reference outputs and load_o in the cycle right after it. The trial code for the MSB appears four cycles after that edge, and result_o and irq_o change twelve edges after it. The reference model in the bench counts cycles since the last start in the same way. It updates at each rising edge using the inputs that were stable there. One time unit later it compares every output against that model, so each result is checked in exactly the cycle it is due. The stimulus covers a restart part-way through a conversion, a continuous chain with a channel change, a clear held across a completion, and the all-zero and all-one codes.

// File: rtl/sar_pkg.sv
// Shared types for the conversion sequencer.
// Assumes nothing beyond a two-bit phase encoding.
package sar_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_HOLD = 2'd2,
        PH_CONV = 2'd3
    } sar_phase_e;
endpackage

// File: rtl/sar_tick_gen.sv
// Prescaler that produces the step enable for the sequencer.
// Assumes PRESCALE >= 1. The count restarts on clr, so a new conversion
// always gets a full first step.
module sar_tick_gen #(
    parameter int PRESCALE = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic [PS_W-1:0] cnt;

    assign tick = (cnt == PS_W'(PRESCALE - 1));

    // Count prescaler cycles; wrap on tick and restart on clr.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sar_phase_ctrl.sv
// Phase controller: load window, hold window, then one step per result bit.
// Assumes 0 < LOAD_CYC < SAMPLE_CYC. A go input restarts from the load
// phase in any state. done pulses with the final bit step.
module sar_phase_ctrl
    import sar_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int LOAD_CYC   = 2,
    parameter int SAMPLE_CYC = 4,
    localparam int BIT_W     = $clog2(DATA_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             go,
    output sar_phase_e       phase,
    output logic [BIT_W-1:0] bit_idx,
    output logic             done
);
    localparam int SC_W = $clog2(SAMPLE_CYC + 1);

    logic [SC_W-1:0] cnt;

    assign done = tick && (phase == PH_CONV) && (bit_idx == '0);

    // Move through the phases on each tick; go wins over everything else.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
        end else if (go) begin
            phase   <= PH_LOAD;
            cnt     <= '0;
            bit_idx <= BIT_W'(DATA_W - 1);
        end else if (tick) begin
            case (phase)
                PH_LOAD: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == SC_W'(LOAD_CYC - 1))
                        phase <= PH_HOLD;
                end
                PH_HOLD: begin
                    if (cnt == SC_W'(SAMPLE_CYC - 1)) begin
                        phase <= PH_CONV;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_CONV: begin
                    if (bit_idx == '0)
                        phase <= PH_IDLE;
                    else
                        bit_idx <= bit_idx - 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sar_search.sv
// Binary-search register with the result and interrupt flag.
// Assumes bit_idx counts down from DATA_W-1 while conv is high, and that
// clr arrives at every conversion start.
module sar_search #(
    parameter int DATA_W = 8,
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clr,
    input  logic              conv,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic              cmp,
    input  logic              done,
    input  logic              irq_clr,
    output logic [DATA_W-1:0] trial,
    output logic [DATA_W-1:0] result,
    output logic              irq
);
    logic [DATA_W-1:0] acc;
    logic [DATA_W-1:0] acc_nxt;

    // Accumulator with the current bit set to the comparator decision.
    always_comb begin
        acc_nxt          = acc;
        acc_nxt[bit_idx] = cmp;
    end

    assign trial = conv ? (acc | (DATA_W'(1) << bit_idx)) : '0;

    // Store one decision per search step; clear on a new start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc <= '0;
        else if (clr)
            acc <= '0;
        else if (tick && conv)
            acc <= acc_nxt;
    end

    // Capture the result and raise the request at completion; a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            irq    <= 1'b0;
        end else begin
            if (done)
                result <= acc_nxt;
            if (done)
                irq <= 1'b1;
            else if (irq_clr)
                irq <= 1'b0;
        end
    end
endmodule

// File: rtl/sar_sequencer.sv
// Top of the successive-approximation sequencer: latches the channel and the
// reference steps at start, then runs the phase controller and search register.
// Assumes cmp_i settles within one cycle of trial_o changing.
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CH_CNT     = 8,
    parameter int REF_W      = 4,
    parameter int LOAD_CYC   = 2,
    parameter int SAMPLE_CYC = 4,
    parameter int PRESCALE   = 1,
    localparam int CH_W      = $clog2(CH_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CH_W-1:0]   chan_i,
    input  logic              cont_i,
    input  logic [REF_W-1:0]  ref_hi_i,
    input  logic [REF_W-1:0]  ref_lo_i,
    input  logic              cmp_i,
    input  logic              irq_clr_i,
    output logic              busy_o,
    output logic              load_o,
    output logic              sample_o,
    output logic [CH_W-1:0]   chan_sel_o,
    output logic [DATA_W-1:0] trial_o,
    output logic [REF_W-1:0]  ref_hi_o,
    output logic [REF_W-1:0]  ref_lo_o,
    output logic [DATA_W-1:0] result_o,
    output logic              irq_o
);
    localparam int BIT_W = $clog2(DATA_W);

    sar_phase_e       phase;
    logic [BIT_W-1:0] bit_idx;
    logic             done;
    logic             tick;
    logic             go;

    assign go = start_i || (done && cont_i);

    sar_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (go),
        .tick  (tick)
    );

    sar_phase_ctrl #(
        .DATA_W     (DATA_W),
        .LOAD_CYC   (LOAD_CYC),
        .SAMPLE_CYC (SAMPLE_CYC)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .go      (go),
        .phase   (phase),
        .bit_idx (bit_idx),
        .done    (done)
    );

    sar_search #(.DATA_W(DATA_W)) u_search (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .clr     (go),
        .conv    (phase == PH_CONV),
        .bit_idx (bit_idx),
        .cmp     (cmp_i),
        .done    (done),
        .irq_clr (irq_clr_i),
        .trial   (trial_o),
        .result  (result_o),
        .irq     (irq_o)
    );

    // Sample the channel and reference steps at each conversion start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_sel_o <= '0;
            ref_hi_o   <= '0;
            ref_lo_o   <= '0;
        end else if (go) begin
            chan_sel_o <= chan_i;
            ref_hi_o   <= ref_hi_i;
            ref_lo_o   <= ref_lo_i;
        end
    end

    assign busy_o   = (phase != PH_IDLE);
    assign load_o   = (phase == PH_LOAD);
    assign sample_o = (phase == PH_LOAD) || (phase == PH_HOLD);
endmodule

// File: rtl/sar_sequencer_chk.sv
// Assertion checker for sar_sequencer, attached with bind.
module sar_sequencer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       irq_clr_i,
    input logic       busy_o,
    input logic       load_o,
    input logic       sample_o,
    input logic [2:0] chan_sel_o,
    input logic [7:0] trial_o,
    input logic [3:0] ref_hi_o,
    input logic [3:0] ref_lo_o,
    input logic       irq_o
);
    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

    // R3
    load_in_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> sample_o);

    // R3
    no_trial_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> (trial_o == 8'd0));

    // R4
    trial_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trial_o != 8'd0) |-> (busy_o && !sample_o));

    // R5
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(busy_o));

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !irq_clr_i) |=> irq_o);

    // R9
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_o && !start_i) |=> ($stable(ref_hi_o) && $stable(ref_lo_o)
                                    && $stable(chan_sel_o)));
endmodule

bind sar_sequencer sar_sequencer_chk u_chk (.*);

// File: tb/tb_sar_sequencer.sv
`timescale 1ns/1ps
module tb_sar_sequencer;
    localparam int LOADC = 2;
    localparam int SAMPC = 4;
    localparam int NBIT  = 8;
    localparam int TOTAL = SAMPC + NBIT;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [2:0] chan = 3'd0;
    logic       cont = 1'b0;
    logic [3:0] rhi = 4'd0;
    logic [3:0] rlo = 4'd0;
    logic       cmp;
    logic       iclr = 1'b0;
    logic       busy, load, sample, irq;
    logic [2:0] csel;
    logic [7:0] trial, result;
    logic [3:0] rhi_o, rlo_o;

    logic [7:0] vin [0:7];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    // Comparator model: input at or above the DAC level
    assign cmp = (vin[csel] >= trial);

    sar_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .chan_i(chan), .cont_i(cont),
        .ref_hi_i(rhi), .ref_lo_i(rlo), .cmp_i(cmp), .irq_clr_i(iclr),
        .busy_o(busy), .load_o(load), .sample_o(sample), .chan_sel_o(csel),
        .trial_o(trial), .ref_hi_o(rhi_o), .ref_lo_o(rlo_o),
        .result_o(result), .irq_o(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Behavioural reference model
    int m_busy = 0, m_step = 0, m_ch = 0, m_hi = 0, m_lo = 0, m_res = 0, m_irq = 0;

    function automatic int exp_trial();
        int b;
        int t;
        if (m_busy == 0 || m_step < SAMPC) return 0;
        b = NBIT - 1 - (m_step - SAMPC);
        t = (int'(vin[m_ch]) >> (b + 1)) << (b + 1);
        return t | (1 << b);
    endfunction

    always @(posedge clk) begin
        bit m_done;
        cyc++;
        if (!rst_n) begin
            m_busy = 0; m_step = 0; m_ch = 0; m_hi = 0; m_lo = 0; m_res = 0; m_irq = 0;
        end else begin
            m_done = (m_busy != 0) && (m_step == TOTAL - 1);
            if (m_done) m_res = vin[m_ch];
            if (iclr) m_irq = 0;
            if (m_done) m_irq = 1;
            if (start || (m_done && cont)) begin
                m_busy = 1; m_step = 0; m_ch = chan; m_hi = rhi; m_lo = rlo;
            end else if (m_done) begin
                m_busy = 0;
            end else if (m_busy != 0) begin
                m_step++;
            end
        end
        #1;
        chk(busy == (m_busy != 0), "R5 busy", busy, m_busy);
        chk(int'(csel) == m_ch, "R2 chan_sel", csel, m_ch);
        chk(load == (m_busy != 0 && m_step < LOADC), "R3 load", load, 0);
        chk(sample == (m_busy != 0 && m_step < SAMPC), "R3 sample", sample, 0);
        chk(int'(trial) == exp_trial(), "R4 trial", trial, exp_trial());
        chk(int'(result) == m_res, "R5 result", result, m_res);
        chk(irq == (m_irq != 0), "R6 irq", irq, m_irq);
        chk(int'(rhi_o) == m_hi, "R9 ref_hi", rhi_o, m_hi);
        chk(int'(rlo_o) == m_lo, "R9 ref_lo", rlo_o, m_lo);
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog all-requirements actual=%0d expected<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic pulse_start(input int ch);
        @(negedge clk);
        start = 1'b1; chan = 3'(ch);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        vin[0] = 8'h00; vin[1] = 8'h3C; vin[2] = 8'h81; vin[3] = 8'hA5;
        vin[4] = 8'h5A; vin[5] = 8'h7F; vin[6] = 8'h01; vin[7] = 8'hFF;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        chk(!busy && !load && !sample, "R1 idle flags", {busy, load, sample}, 0);
        chk(trial == 8'd0 && result == 8'd0, "R1 codes", result, 0);
        chk(!irq, "R1 irq", irq, 0);

        // R2, R9: single conversion, inputs change afterwards
        rhi = 4'hC; rlo = 4'h2;
        pulse_start(3);
        chan = 3'd6; rhi = 4'h5; rlo = 4'hE;
        idle(13);
        chk(result == 8'hA5, "R5 single result", result, 8'hA5);
        chk(irq, "R5 irq set", irq, 1);
        chk(csel == 3'd3, "R2 chan held", csel, 3);
        chk(rhi_o == 4'hC && rlo_o == 4'h2, "R9 refs held", {rhi_o, rlo_o}, 8'hC2);

        // R6 clear
        idle(3);
        chk(irq, "R6 irq stays", irq, 1);
        iclr = 1'b1; idle(1); iclr = 1'b0;
        chk(!irq, "R6 irq cleared", irq, 0);

        // R4 corner codes
        pulse_start(0); idle(13);
        chk(result == 8'h00, "R4 zero code", result, 0);
        pulse_start(7); idle(13);
        chk(result == 8'hFF, "R4 full code", result, 8'hFF);

        // R8 restart while busy
        iclr = 1'b1; idle(1); iclr = 1'b0;
        pulse_start(1); idle(6);
        pulse_start(5); idle(4);
        chk(!irq && result == 8'hFF, "R8 old conversion dropped", result, 8'hFF);
        idle(9);
        chk(result == 8'h7F, "R8 restart result", result, 8'h7F);

        // R6 clear held through completion
        iclr = 1'b1;
        pulse_start(4); idle(14);
        iclr = 1'b0;
        idle(2);

        // R7 continuous with channel change
        cont = 1'b1;
        pulse_start(2);
        chan = 3'd6; rhi = 4'h9; rlo = 4'h3;
        idle(30);
        chk(busy, "R7 still running", busy, 1);
        chk(csel == 3'd6 && rhi_o == 4'h9, "R7 resampled", {csel, rhi_o}, 8'h69);
        cont = 1'b0;
        idle(14);
        chk(!busy, "R7 stops", busy, 0);
        chk(result == 8'h01, "R7 last result", result, 8'h01);

        // New input level while idle
        vin[3] = 8'h4B;
        pulse_start(3); idle(14);
        chk(result == 8'h4B, "R4 new level", result, 8'h4B);

        idle(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule